// File: doc/BRIEF.md
# Time-over-threshold hit encoder

This block turns the digitised discriminator outputs of a strip-detector front end into time-stamped edge records. Every channel delivers two comparator bits: a low-threshold bit and a high-threshold bit. The block samples both bits once per event period. It detects rising and falling transitions and writes one record for each kept transition into a shared FIFO. The record carries the channel number, whether the edge is leading or trailing, which comparator produced it, and the event-time count. The offline pulse height comes from the time between a leading record and its trailing record.

The low comparator gates the high one. A high-threshold level only counts while the same channel's low bit is sampled high. When the low bit drops, any open high-threshold interval is closed in that same sample. Zero suppression forwards high-threshold records unconditionally. It forwards low-threshold records only for channels that are hit or that sit directly next to a hit channel, so that a downstream centroid still sees the neighbours. The block runs on the fast multiplex clock. The event period is NCH cycles of that clock, and one channel is visited per cycle.

Top module: `tot_hit_encoder`

## Requirements
- R1: After reset, `rd_valid` and `overflow` are 0. Idle comparator inputs produce no records.
- R2: The comparators are sampled at every NCH-th rising edge of `clk` after reset, starting with the NCH-th edge. The k-th sample (k = 0, 1, …) carries the timestamp k modulo 2^TSW.
- R3: The high-threshold state of a channel is the AND of its sampled high bit and its sampled low bit. A high bit that rises while the low bit is low produces no record.
- R4: A rising sampled low bit gives a low record with trail=0. A rising high-threshold state gives a high record with trail=0. Both carry the timestamp of the sample in which the change was seen.
- R5: A falling high-threshold state gives a high record with trail=1. When the low bit falls while the high-threshold state is open, that same sample closes the high interval with a high record with trail=1 and also gives a low record with trail=1.
- R6: Records of one sample appear in ascending channel order. Within one channel, a low leading record comes before a high record, and a high record comes before a low trailing record.
- R7: A channel is active when its high-threshold state is 1 in the current sample or the previous one. Low records of channel c are kept only if channel c-1, c or c+1 is active. Channels outside 0..NCH-1 count as inactive, with no wraparound between channel 0 and channel NCH-1.
- R8: The read port shows the oldest record whenever `rd_valid` is 1. Asserting `rd_en` while `rd_valid` is 1 removes that record at the clock edge. Records leave in the order they were written.
- R9: A record that finds the FIFO full (DEPTH entries) is discarded and `overflow` becomes 1. `overflow` stays 1 until `clr_ovf` is sampled high or reset is applied. A discard in the same cycle as `clr_ovf` leaves `overflow` at 1.
- R10: The event-time counter wraps from 2^TSW-1 to 0, and records after the wrap carry the wrapped value.
- Record fields: `rd_chan` is the channel index, `rd_trail` is 1 for a trailing edge, and `rd_hi` is 1 for the high comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplex clock; one channel visited per cycle |
| rst_n | input | 1 | Active-low synchronous reset of all state |
| clr_ovf | input | 1 | Clears the sticky overflow flag |
| cmp_lo | input | NCH | Low-threshold comparator bit per channel |
| cmp_hi | input | NCH | High-threshold comparator bit per channel |
| rd_en | input | 1 | Pops the oldest record |
| rd_valid | output | 1 | FIFO holds at least one record |
| rd_chan | output | $clog2(NCH) | Channel index of the oldest record |
| rd_trail | output | 1 | 1 = trailing edge, 0 = leading edge |
| rd_hi | output | 1 | 1 = high comparator, 0 = low comparator |
| rd_time | output | TSW | Event-time count of the sample |
| overflow | output | 1 | Sticky flag: a record was discarded |

## Verification
A change on the comparator inputs is seen only at the next sampling edge, the one that ends an event period. Channel c's records are written c+1 edges after that sampling edge. A record is therefore on the read port at most NCH+1 edges after the sample. The bench counts edges from reset release. It drives inputs on the falling edge just before a sampling edge and waits NCH+1 rising edges before it reads anything, so every record of that sample is in place. The expected timestamp is the edge count at drive time divided by NCH. Flags such as `overflow` are read on the falling edge after the edge that changes them.

// File: rtl/tot_hit_encoder.sv
module tot_hit_encoder #(
  parameter int NCH   = 8,
  parameter int TSW   = 16,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_ovf,
  input  logic [NCH-1:0]         cmp_lo,
  input  logic [NCH-1:0]         cmp_hi,
  input  logic                   rd_en,
  output logic                   rd_valid,
  output logic [$clog2(NCH)-1:0] rd_chan,
  output logic                   rd_trail,
  output logic                   rd_hi,
  output logic [TSW-1:0]         rd_time,
  output logic                   overflow
);
  localparam int CW = $clog2(NCH);
  localparam int AW = $clog2(DEPTH);
  localparam int RW = CW + 2 + TSW;

  logic [CW-1:0] ph;
  logic          tick;
  assign tick = (ph == CW'(NCH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    ph <= '0;
    else if (tick) ph <= '0;
    else           ph <= ph + CW'(1);
  end

  logic [NCH-1:0] lo_cur, lo_prv, qh_cur, qh_prv;
  logic [TSW-1:0] ts_cnt, ts_smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cur <= '0;
      lo_prv <= '0;
      qh_cur <= '0;
      qh_prv <= '0;
      ts_cnt <= '0;
      ts_smp <= '0;
    end else if (tick) begin
      lo_prv <= lo_cur;
      lo_cur <= cmp_lo;
      qh_prv <= qh_cur;
      qh_cur <= cmp_lo & cmp_hi;
      ts_smp <= ts_cnt;
      ts_cnt <= ts_cnt + TSW'(1);
    end
  end

  logic [NCH-1:0] act, keep;
  logic [NCH+1:0] act_pad;
  assign act     = qh_cur | qh_prv;
  assign act_pad = {1'b0, act, 1'b0};

  for (genvar i = 0; i < NCH; i++) begin : g_keep
    assign keep[i] = |act_pad[i+2:i];
  end

  logic          lo_ok, hi_ev, lo_first;
  logic [1:0]    n_req;
  logic [RW-1:0] rec_lo, rec_hi, rec_a, rec_b;

  assign lo_ok    = (lo_cur[ph] ^ lo_prv[ph]) & keep[ph];
  assign hi_ev    = qh_cur[ph] ^ qh_prv[ph];
  assign lo_first = lo_ok & lo_cur[ph];
  assign n_req    = {1'b0, lo_ok} + {1'b0, hi_ev};
  assign rec_lo   = {ph, ~lo_cur[ph], 1'b0, ts_smp};
  assign rec_hi   = {ph, ~qh_cur[ph], 1'b1, ts_smp};
  assign rec_a    = (lo_first || !hi_ev) ? rec_lo : rec_hi;
  assign rec_b    = lo_first ? rec_hi : rec_lo;

  logic [RW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt, room;
  logic [1:0]    n_wr;
  logic          pop, drop;

  assign room = (AW+1)'(DEPTH) - cnt;
  assign n_wr = (room >= (AW+1)'(n_req)) ? n_req : room[1:0];
  assign drop = (n_wr != n_req);
  assign pop  = rd_en && (cnt != '0);

  always_ff @(posedge clk) begin
    if (n_wr != 2'd0) mem[wptr] <= rec_a;
    if (n_wr == 2'd2) mem[wptr + AW'(1)] <= rec_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      wptr <= wptr + AW'(n_wr);
      rptr <= rptr + AW'(pop);
      cnt  <= cnt + (AW+1)'(n_wr) - (AW+1)'(pop);
      if (drop)         overflow <= 1'b1;
      else if (clr_ovf) overflow <= 1'b0;
    end
  end

  assign rd_valid = (cnt != '0);
  assign {rd_chan, rd_trail, rd_hi, rd_time} = mem[rptr];

  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ts_cnt == ts_smp + TSW'(1)));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  p_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && n_wr == 2'd0) |=> (cnt == $past(cnt) - (AW+1)'(1)));

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);

  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow);
endmodule

// File: tb/tot_hit_encoder_test.sv
module tot_hit_encoder_test;
  localparam int PERIOD = 10;
  localparam int NCH    = 8;
  localparam int TSW    = 4;
  localparam int DEPTH  = 16;
  localparam int CW     = 3;
  localparam int RW     = CW + 2 + TSW;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           clr_ovf = 0;
  logic [NCH-1:0] cmp_lo = '0;
  logic [NCH-1:0] cmp_hi = '0;
  logic           rd_en = 0;
  logic           rd_valid, rd_trail, rd_hi, overflow;
  logic [CW-1:0]  rd_chan;
  logic [TSW-1:0] rd_time;

  tot_hit_encoder #(.NCH(NCH), .TSW(TSW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .clr_ovf(clr_ovf), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_chan(rd_chan), .rd_trail(rd_trail),
    .rd_hi(rd_hi), .rd_time(rd_time), .overflow(overflow));

  always #(PERIOD/2) clk = ~clk;

  int ec = 0;
  always @(posedge clk) begin
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  logic [NCH-1:0] m_lo = '0, m_qh = '0;
  logic [RW-1:0]  expq[$];
  int             m_cnt = 0;
  bit             exp_ovf = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void push(input logic [RW-1:0] r);
    if (m_cnt < DEPTH) begin
      expq.push_back(r);
      m_cnt++;
    end else exp_ovf = 1;
  endfunction

  task automatic sample(input logic [NCH-1:0] lo, input logic [NCH-1:0] hi);
    logic [NCH-1:0] qh, act;
    logic [TSW-1:0] ts;
    @(negedge clk);
    while (ec % NCH != NCH - 1) @(negedge clk);
    cmp_lo = lo;
    cmp_hi = hi;
    ts  = TSW'(ec / NCH);
    qh  = lo & hi;
    act = qh | m_qh;
    for (int c = 0; c < NCH; c++) begin
      bit lo_ev, hi_ev, kp;
      lo_ev = lo[c] != m_lo[c];
      hi_ev = qh[c] != m_qh[c];
      kp = act[c] || (c > 0 && act[c-1]) || (c < NCH - 1 && act[c+1]);
      if (lo_ev && kp && lo[c]) push({CW'(c), 1'b0, 1'b0, ts});
      if (hi_ev) push({CW'(c), ~qh[c], 1'b1, ts});
      if (lo_ev && kp && !lo[c]) push({CW'(c), 1'b1, 1'b0, ts});
    end
    m_lo = lo;
    m_qh = qh;
    repeat (NCH + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    logic [RW-1:0] got, exp;
    for (int n = 0; n < 40 && rd_valid; n++) begin
      got = {rd_chan, rd_trail, rd_hi, rd_time};
      if (expq.size() == 0) check(0, {tag, " unexpected record"}, int'(got), 0);
      else begin
        exp = expq.pop_front();
        check(got == exp, {tag, " record"}, int'(got), int'(exp));
      end
      rd_en = 1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 0;
    end
    check(expq.size() == 0, {tag, " missing records"}, 0, expq.size());
    expq.delete();
    m_cnt = 0;
  endtask

  task automatic t_reset;
    check(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
    check(overflow == 0, "R1 overflow after reset", overflow, 0);
    sample('0, '0);
    drain("R1 idle");
  endtask

  task automatic t_window;
    sample(8'h00, 8'h08);
    check(rd_valid == 0, "R3 high bit outside window", rd_valid, 0);
    drain("R3");
    sample(8'h08, 8'h08);
    drain("R4 leading pair");
    sample(8'h08, 8'h00);
    drain("R5 high trailing");
    sample(8'h08, 8'h08);
    drain("R4 high re-lead");
    sample(8'h00, 8'h08);
    drain("R5 window close");
    sample(8'h00, 8'h00);
    drain("R3 idle after close");
  endtask

  task automatic t_order;
    sample(8'h0E, 8'h0A);
    drain("R6 channel order");
    sample(8'h00, 8'h00);
    drain("R6 trailing order");
  endtask

  task automatic t_suppress;
    sample(8'h20, 8'h00);
    check(rd_valid == 0, "R7 lone low dropped", rd_valid, 0);
    sample(8'h00, 8'h00);
    check(rd_valid == 0, "R7 lone low trail dropped", rd_valid, 0);
    sample(8'h83, 8'h01);
    drain("R7 low edge channel 0");
    sample(8'h00, 8'h00);
    drain("R7 low edge channel 0 trail");
    sample(8'hC1, 8'h80);
    drain("R7 high edge channel");
    sample(8'h00, 8'h00);
    drain("R7 high edge trail");
  endtask

  task automatic t_fifo;
    sample(8'hFF, 8'hFF);
    check(overflow == 0, "R9 full without discard", overflow, 0);
    sample(8'h00, 8'h00);
    check(overflow == 1, "R9 overflow set", overflow, 1);
    check(exp_ovf == 1, "R9 model discard", exp_ovf, 1);
    drain("R8 full fifo order");
    check(rd_valid == 0, "R8 empty after drain", rd_valid, 0);
    check(overflow == 1, "R9 overflow sticky", overflow, 1);
    clr_ovf = 1;
    @(posedge clk);
    @(negedge clk);
    clr_ovf = 0;
    check(overflow == 0, "R9 overflow cleared", overflow, 0);
    exp_ovf = 0;
  endtask

  task automatic t_time;
    repeat (3 * NCH) @(posedge clk);
    sample(8'h04, 8'h04);
    drain("R2 timestamp after idle");
    sample(8'h00, 8'h00);
    drain("R2 timestamp trail");
    check(ec / NCH >= (1 << TSW), "R10 counter passed wrap", ec / NCH, 1 << TSW);
    sample(8'h10, 8'h10);
    drain("R10 wrapped timestamp");
    sample(8'h00, 8'h00);
    drain("R10 wrapped timestamp trail");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_order();
    t_suppress();
    t_fifo();
    t_time();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule